// File: doc/BRIEF.md
# Per-CPU Interrupt Interface

This block is the register front end that one processor core uses to take interrupts from a shared distributor. The distributor presents, every cycle, the ID of the best interrupt pending for this core and that interrupt's priority. The block decides whether to raise the core's interrupt line. It lets software acknowledge the interrupt, which returns its ID and claims it, and retire it again with an end-of-interrupt write. It tells the distributor about each claim and each retirement with one-cycle strobes.

Software reaches the block through a simple request/response port. A request is accepted in the cycle `req_valid` is high, and its response appears one cycle later. The register offsets are: 0x00 control (bit 0 enables the interface), 0x04 priority mask, 0x08 binary point (a placeholder), 0x0C acknowledge (read), 0x10 end-of-interrupt (write), 0x14 running priority (read) and 0x18 highest pending ID (read). The ID value 1023 means "no interrupt". The running priority rests at 0x100, which is above every real 8-bit priority.

Two state machines sit inside the block. The bus machine has the states BUS_IDLE and BUS_RESP. The transition ISSUE is taken on every accepted request and DRAIN is taken when no request follows. The running machine has the states RUN_IDLE and RUN_ACTIVE. TAKE is a valid acknowledge, which enters RUN_ACTIVE or re-enters it from RUN_ACTIVE. RETIRE is an end-of-interrupt whose ID matches the running interrupt, and it returns the machine to RUN_IDLE.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset, control reads 0, the priority mask reads 0xF0, the running priority reads 0x100, the highest pending ID reads 1023, and `irq` is low.
- R2: A write to offset 0x00 stores only bit 0, the interface enable. A later read of 0x00 returns that bit in bit 0, with every other bit zero.
- R3: A write to offset 0x04 stores write-data bits [7:0] as the priority mask. A read of 0x04 returns the mask in bits [7:0].
- R4: Offset 0x08 always reads zero. Writes to 0x08 are accepted without error and have no effect.
- R5: `irq` is high exactly when all of the following hold: `dist_enable` is high, the interface is enabled, the registered pending ID is not 1023, and the registered pending priority is strictly below both the mask and the running priority.
- R6: A read of 0x0C while the registered pending ID is not 1023 returns that ID. It pulses `ack_valid` for one cycle with `ack_id` equal to that ID, and loads the running priority from the pending priority.
- R7: A read of 0x0C while the registered pending ID is 1023 returns 1023, gives no `ack_valid`, and leaves the running priority unchanged.
- R8: A write to 0x10 whose bits [9:0] equal the running interrupt's ID returns the running priority to 0x100. It also pulses `eoi_valid` for one cycle with `eoi_id` equal to that ID.
- R9: A write to 0x10 whose ID does not match the running interrupt gives no `eoi_valid` and leaves the running priority unchanged.
- R10: The following requests respond with `rsp_err` high and data zero, and change no state: a read of 0x10, a write to 0x0C, 0x14 or 0x18, and any other offset.
- R11: A read of 0x18 returns the distributor's pending ID as registered one cycle before the request is accepted.
- R12: Every accepted request gets `rsp_valid` high in the following cycle, and `rsp_valid` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 10 | Write data (low bits of the bus word) |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_err | output | 1 | Response flags an illegal access |
| rsp_rdata | output | 32 | Read data |
| dist_enable | input | 1 | Distributor global enable |
| pend_id | input | 10 | Highest pending interrupt ID for this CPU, 1023 = none |
| pend_prio | input | 8 | Priority of that interrupt, lower is more urgent |
| irq | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | One-cycle strobe: an interrupt was claimed |
| ack_id | output | 10 | ID claimed, 1023 when no strobe |
| eoi_valid | output | 1 | One-cycle strobe: an interrupt was retired |
| eoi_id | output | 10 | ID retired, 1023 when no strobe |

## Verification
If the running priority is stuck or wrong, the first acknowledge or end-of-interrupt after the fault exposes it. The response after an acknowledge shows whether `irq` drops, and a read of 0x14 shows the stored value directly. A wrongly stored mask or enable shows on `irq` in the first cycle after the pending inputs settle. A decode fault appears in the response right after the bad access as a wrong `rsp_err` or wrong data. A later read then shows whether that bad access corrupted the mask.

// File: rtl/cpu_irq_iface_pkg.sv
package cpu_irq_iface_pkg;

    // Bus-side handshake state
    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    // Running-interrupt state
    typedef enum logic [0:0] {
        RUN_IDLE   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    // Decoded register operation
    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_BAD   = 4'd1,
        OP_CTRL  = 4'd2,
        OP_MASK  = 4'd3,
        OP_BPR   = 4'd4,
        OP_ACK   = 4'd5,
        OP_EOI   = 4'd6,
        OP_RUN   = 4'd7,
        OP_HPEND = 4'd8
    } reg_op_e;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_BPR   = 8'h08;
    localparam logic [7:0] OFS_ACK   = 8'h0C;
    localparam logic [7:0] OFS_EOI   = 8'h10;
    localparam logic [7:0] OFS_RUN   = 8'h14;
    localparam logic [7:0] OFS_HPEND = 8'h18;

endpackage

// File: rtl/cpuif_decode.sv
module cpuif_decode
    import cpu_irq_iface_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output reg_op_e           op
);

    always_comb begin
        op = OP_NONE;
        if (req_valid) begin
            op = OP_BAD;
            if (req_addr == ADDR_W'(OFS_CTRL)) begin
                op = OP_CTRL;
            end else if (req_addr == ADDR_W'(OFS_MASK)) begin
                op = OP_MASK;
            end else if (req_addr == ADDR_W'(OFS_BPR)) begin
                op = OP_BPR;
            end else if (req_addr == ADDR_W'(OFS_ACK)) begin
                op = req_write ? OP_BAD : OP_ACK;
            end else if (req_addr == ADDR_W'(OFS_EOI)) begin
                op = req_write ? OP_EOI : OP_BAD;
            end else if (req_addr == ADDR_W'(OFS_RUN)) begin
                op = req_write ? OP_BAD : OP_RUN;
            end else if (req_addr == ADDR_W'(OFS_HPEND)) begin
                op = req_write ? OP_BAD : OP_HPEND;
            end
        end
    end

endmodule

// File: rtl/cpuif_run_fsm.sv
module cpuif_run_fsm
    import cpu_irq_iface_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [ID_W-1:0] take_id,
    input  logic [PRIO_W-1:0] take_prio,
    input  logic            eoi_req,
    input  logic [ID_W-1:0] eoi_req_id,
    output logic [PRIO_W:0] run_prio,
    output logic [ID_W-1:0] run_id,
    output logic            eoi_hit
);

    localparam logic [ID_W-1:0] NONE_ID   = {ID_W{1'b1}};
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

    run_state_e state_q, state_d;
    logic [PRIO_W:0] prio_d;
    logic [ID_W-1:0] id_d;

    // RETIRE condition: matching completion of the running interrupt
    assign eoi_hit = (state_q == RUN_ACTIVE) && eoi_req && (eoi_req_id == run_id);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RUN_IDLE;
            run_prio <= IDLE_PRIO;
            run_id   <= NONE_ID;
        end else begin
            state_q  <= state_d;
            run_prio <= prio_d;
            run_id   <= id_d;
        end
    end

    always_comb begin
        state_d = state_q;
        prio_d  = run_prio;
        id_d    = run_id;
        unique case (state_q)
            RUN_IDLE: begin
                if (take) begin                      // TAKE
                    state_d = RUN_ACTIVE;
                    prio_d  = {1'b0, take_prio};
                    id_d    = take_id;
                end
            end
            RUN_ACTIVE: begin
                if (take) begin                      // TAKE (replaces)
                    prio_d = {1'b0, take_prio};
                    id_d   = take_id;
                end else if (eoi_hit) begin          // RETIRE
                    state_d = RUN_IDLE;
                    prio_d  = IDLE_PRIO;
                    id_d    = NONE_ID;
                end
            end
            default: begin
                state_d = RUN_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/cpuif_irq_gate.sv
module cpuif_irq_gate #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic              dist_enable,
    input  logic              cpu_enable,
    input  logic [ID_W-1:0]   cur_id,
    input  logic [PRIO_W-1:0] cur_prio,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [PRIO_W:0]   run_prio,
    output logic              irq
);

    localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

    logic has_pend, beats_mask, beats_run;

    always_comb begin
        has_pend   = (cur_id != NONE_ID);
        beats_mask = (cur_prio < prio_mask);
        beats_run  = ({1'b0, cur_prio} < run_prio);
        irq        = dist_enable && cpu_enable && has_pend && beats_mask && beats_run;
    end

endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
    import cpu_irq_iface_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int ID_W     = 10,
    parameter int PRIO_W   = 8,
    parameter int DATA_W   = 32,
    parameter logic [PRIO_W-1:0] MASK_RST = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [((ID_W > PRIO_W) ? ID_W : PRIO_W)-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              dist_enable,
    input  logic [ID_W-1:0]   pend_id,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              irq,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_valid,
    output logic [ID_W-1:0]   eoi_id
);

    localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};

    // Registered view of the distributor's offer
    logic [ID_W-1:0]   cur_id_q;
    logic [PRIO_W-1:0] cur_prio_q;

    // Software-visible registers
    logic              cpu_en_q;
    logic [PRIO_W-1:0] mask_q;

    // Bus machine
    bus_state_e bus_q, bus_d;

    reg_op_e           op;
    logic              take;
    logic              eoi_req;
    logic              eoi_hit;
    logic [PRIO_W:0]   run_prio;
    logic [ID_W-1:0]   run_id;
    logic [DATA_W-1:0] rd_mux;

    cpuif_decode #(.ADDR_W(ADDR_W)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .op        (op)
    );

    assign take    = (op == OP_ACK) && (cur_id_q != NONE_ID);
    assign eoi_req = (op == OP_EOI);

    cpuif_run_fsm #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take),
        .take_id    (cur_id_q),
        .take_prio  (cur_prio_q),
        .eoi_req    (eoi_req),
        .eoi_req_id (req_wdata[ID_W-1:0]),
        .run_prio   (run_prio),
        .run_id     (run_id),
        .eoi_hit    (eoi_hit)
    );

    cpuif_irq_gate #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_gate (
        .dist_enable (dist_enable),
        .cpu_enable  (cpu_en_q),
        .cur_id      (cur_id_q),
        .cur_prio    (cur_prio_q),
        .prio_mask   (mask_q),
        .run_prio    (run_prio),
        .irq         (irq)
    );

    // Snapshot of the distributor's offer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_id_q   <= NONE_ID;
            cur_prio_q <= '0;
        end else begin
            cur_id_q   <= pend_id;
            cur_prio_q <= pend_prio;
        end
    end

    // Control and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_en_q <= 1'b0;
            mask_q   <= MASK_RST;
        end else if (req_write) begin
            if (op == OP_CTRL) begin
                cpu_en_q <= req_wdata[0];
            end
            if (op == OP_MASK) begin
                mask_q <= req_wdata[PRIO_W-1:0];
            end
        end
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (!req_write) begin
            unique case (op)
                OP_CTRL:  rd_mux = DATA_W'(cpu_en_q);
                OP_MASK:  rd_mux = DATA_W'(mask_q);
                OP_ACK:   rd_mux = DATA_W'(cur_id_q);
                OP_RUN:   rd_mux = DATA_W'(run_prio);
                OP_HPEND: rd_mux = DATA_W'(cur_id_q);
                default:  rd_mux = '0;
            endcase
        end
    end

    // Bus state register: ISSUE / DRAIN
    always_comb begin
        unique case (bus_q)
            BUS_IDLE: bus_d = req_valid ? BUS_RESP : BUS_IDLE;
            BUS_RESP: bus_d = req_valid ? BUS_RESP : BUS_IDLE;
            default:  bus_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_q <= BUS_IDLE;
        end else begin
            bus_q <= bus_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            ack_valid <= 1'b0;
            ack_id    <= NONE_ID;
            eoi_valid <= 1'b0;
            eoi_id    <= NONE_ID;
        end else begin
            rsp_err   <= (op == OP_BAD);
            rsp_rdata <= rd_mux;
            ack_valid <= take;
            ack_id    <= take ? cur_id_q : NONE_ID;
            eoi_valid <= eoi_hit;
            eoi_id    <= eoi_hit ? run_id : NONE_ID;
        end
    end

    assign rsp_valid = (bus_q == BUS_RESP);

endmodule

// File: rtl/cpu_irq_iface_chk.sv
module cpu_irq_iface_chk #(
    parameter int ADDR_W = 8,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic              dist_enable,
    input logic              irq,
    input logic              ack_valid,
    input logic [ID_W-1:0]   ack_id,
    input logic              eoi_valid,
    input logic [PRIO_W:0]   run_prio
);

    localparam logic [ID_W-1:0] NONE_ID   = {ID_W{1'b1}};
    localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [ADDR_W-1:0] ACK_OFS = ADDR_W'(8'h0C);

    p_ack_real_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ack_id != NONE_ID));

    p_ack_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(req_valid && !req_write && (req_addr == ACK_OFS)));

    p_ack_loads_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (run_prio[PRIO_W] == 1'b0));

    p_eoi_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (run_prio == IDLE_PRIO));

    p_irq_dist_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> dist_enable);

    p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_caused_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && !ack_valid && !eoi_valid));

endmodule

bind cpu_irq_iface cpu_irq_iface_chk #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .dist_enable (dist_enable),
    .irq         (irq),
    .ack_valid   (ack_valid),
    .ack_id      (ack_id),
    .eoi_valid   (eoi_valid),
    .run_prio    (run_prio)
);

// File: tb/cpu_irq_iface_test.sv
module cpu_irq_iface_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] NONE = 10'd1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [9:0]  req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        dist_enable = 1'b0;
    logic [9:0]  pend_id = NONE;
    logic [7:0]  pend_prio = '0;
    logic        irq, ack_valid, eoi_valid;
    logic [9:0]  ack_id, eoi_id;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model
    logic       m_en = 1'b0;
    logic [7:0] m_mask = 8'hF0;
    logic [8:0] m_run = 9'h100;
    logic [9:0] m_run_id = NONE;

    // Captured response
    logic [31:0] c_rd;
    logic        c_err, c_ackv, c_eoiv, c_rv;
    logic [9:0]  c_ackid, c_eoiid;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_irq_iface uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .dist_enable(dist_enable), .pend_id(pend_id), .pend_prio(pend_prio),
        .irq(irq), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id)
    );

    function automatic logic exp_irq();
        return dist_enable && m_en && (pend_id != NONE) &&
               (pend_prio < m_mask) && ({1'b0, pend_prio} < m_run);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request; samples everything in the response cycle
    task automatic bus(input logic wr, input logic [7:0] a, input logic [9:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        c_rv = rsp_valid; c_rd = rsp_rdata; c_err = rsp_err;
        c_ackv = ack_valid; c_ackid = ack_id; c_eoiv = eoi_valid; c_eoiid = eoi_id;
        chk("R12 rsp_valid", {31'b0, c_rv}, 32'd1);
    endtask

    task automatic set_pend(input logic [9:0] id, input logic [7:0] pr);
        @(negedge clk);
        pend_id = id; pend_prio = pr;
    endtask

    task automatic do_ack();
        logic [9:0] exp_id;
        logic       valid;
        exp_id = pend_id;
        valid  = (pend_id != NONE);
        bus(1'b0, 8'h0C, '0);
        chk(valid ? "R6 ack data" : "R7 ack data", c_rd, {22'b0, exp_id});
        chk(valid ? "R6 ack strobe" : "R7 no strobe", {31'b0, c_ackv}, {31'b0, valid});
        if (valid) begin
            chk("R6 ack_id", {22'b0, c_ackid}, {22'b0, exp_id});
            m_run = {1'b0, pend_prio};
            m_run_id = exp_id;
        end
    endtask

    task automatic do_eoi(input logic [9:0] id);
        logic hit;
        hit = (m_run_id != NONE) && (id == m_run_id);
        bus(1'b1, 8'h10, id);
        chk(hit ? "R8 eoi strobe" : "R9 no eoi", {31'b0, c_eoiv}, {31'b0, hit});
        if (hit) begin
            chk("R8 eoi_id", {22'b0, c_eoiid}, {22'b0, id});
            m_run = 9'h100;
            m_run_id = NONE;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        @(negedge clk);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        bus(1'b0, 8'h00, '0); chk("R1 ctrl", c_rd, 32'd0);
        bus(1'b0, 8'h04, '0); chk("R1 mask", c_rd, 32'hF0);
        bus(1'b0, 8'h14, '0); chk("R1 running", c_rd, 32'h100);
        bus(1'b0, 8'h18, '0); chk("R1 hpend", c_rd, 32'd1023);

        // R2 control
        bus(1'b1, 8'h00, 10'h3FF); bus(1'b0, 8'h00, '0); chk("R2 ctrl set", c_rd, 32'd1);
        bus(1'b1, 8'h00, 10'h3FE); bus(1'b0, 8'h00, '0); chk("R2 ctrl clr", c_rd, 32'd0);
        bus(1'b1, 8'h00, 10'h001); m_en = 1'b1;

        // R3 mask
        bus(1'b1, 8'h04, 10'h2A5); bus(1'b0, 8'h04, '0); chk("R3 mask", c_rd, 32'hA5);
        m_mask = 8'hA5;

        // R4 binary point
        bus(1'b1, 8'h08, 10'h3FF); chk("R4 bpr wr err", {31'b0, c_err}, 32'd0);
        bus(1'b0, 8'h08, '0); chk("R4 bpr rd", c_rd, 32'd0);

        // R10 illegal accesses
        bus(1'b0, 8'h10, '0); chk("R10 rd eoi err", {31'b0, c_err}, 32'd1);
        chk("R10 rd eoi data", c_rd, 32'd0);
        bus(1'b1, 8'h18, 10'h005); chk("R10 wr hpend err", {31'b0, c_err}, 32'd1);
        bus(1'b1, 8'h14, 10'h005); chk("R10 wr run err", {31'b0, c_err}, 32'd1);
        bus(1'b1, 8'h0C, 10'h005); chk("R10 wr ack err", {31'b0, c_err}, 32'd1);
        bus(1'b1, 8'h05, 10'h000); chk("R10 unaligned err", {31'b0, c_err}, 32'd1);
        bus(1'b0, 8'h20, '0); chk("R10 far err", {31'b0, c_err}, 32'd1);
        bus(1'b0, 8'h04, '0); chk("R10 mask intact", c_rd, 32'hA5);

        // R11 pending readout
        set_pend(10'd37, 8'h40);
        bus(1'b0, 8'h18, '0); chk("R11 hpend", c_rd, 32'd37);

        // R5 gating
        dist_enable = 1'b1;
        @(negedge clk); chk("R5 irq on", {31'b0, irq}, 32'd1);
        dist_enable = 1'b0;
        @(negedge clk); chk("R5 dist off", {31'b0, irq}, 32'd0);
        dist_enable = 1'b1;
        bus(1'b1, 8'h04, 10'h040); m_mask = 8'h40;
        chk("R5 mask equal", {31'b0, irq}, 32'd0);
        bus(1'b1, 8'h04, 10'h041); m_mask = 8'h41;
        chk("R5 mask above", {31'b0, irq}, 32'd1);

        // R6 acknowledge, R9/R8 completion
        do_ack();
        bus(1'b0, 8'h14, '0); chk("R6 running", c_rd, 32'h40);
        chk("R6 irq masked by running", {31'b0, irq}, 32'd0);
        do_eoi(10'd36);
        bus(1'b0, 8'h14, '0); chk("R9 running kept", c_rd, 32'h40);
        do_eoi(10'd37);
        bus(1'b0, 8'h14, '0); chk("R8 running idle", c_rd, 32'h100);

        // R7 empty acknowledge
        set_pend(NONE, 8'h00);
        do_ack();
        bus(1'b0, 8'h14, '0); chk("R7 running kept", c_rd, 32'h100);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [9:0] id;
            id = (($urandom % 5) == 0) ? NONE : 10'($urandom % 40);
            set_pend(id, 8'($urandom));
            dist_enable = (($urandom % 6) != 0);
            sel = $urandom % 6;
            case (sel)
                0: begin
                    logic b;
                    b = (($urandom % 4) != 0);
                    bus(1'b1, 8'h00, {9'($urandom), b}); m_en = b;
                end
                1: begin
                    logic [7:0] mk;
                    mk = 8'($urandom);
                    bus(1'b1, 8'h04, {2'b00, mk}); m_mask = mk;
                end
                2: do_ack();
                3: do_eoi((($urandom % 2) == 0) ? m_run_id : 10'($urandom % 40));
                4: begin
                    bus(1'b0, 8'h14, '0); chk("R6 R8 running", c_rd, {23'b0, m_run});
                end
                default: begin
                    bus(1'b0, 8'h18, '0); chk("R11 hpend", c_rd, {22'b0, pend_id});
                end
            endcase
            chk("R5 irq", {31'b0, irq}, {31'b0, exp_irq()});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule